// File: doc/BRIEF.md
# Vector Operand Legality Checker

This block sits in the decode stage of a vector unit and decides whether a vector instruction may issue given its register operands and the current vector type settings. It receives an operand-form class, the destination register number and two source register numbers, the mask-enable bit, the vector-unit status field, the element-width code and the signed register-grouping code. It returns one flag: high when the operand combination is legal, low when the instruction must raise an illegal-instruction exception.

Each operand carries its own effective grouping (log2 of the number of registers it spans), which is the current grouping for ordinary operands and one step more for double-width operands. From that the block derives each operand's start and span, checks alignment and range per operand, and tests destination-versus-source overlap per source, allowing overlap only in the position that the relative element widths permit. The check is purely combinational; no clock or reset is involved.

Top module: `vlc_legal_check`

## Requirements
- R1: When `vs_status` is 0 the flag `legal` is 0 for every class and operand set.
- R2: The grouping code `vlmul` is a 3-bit two's-complement log2 value (-3..3); the code 3'b100 is reserved and forces `legal` to 0. Class codes 9 to 15 are undefined and force `legal` to 0.
- R3: An operand with effective log2 grouping E spans 1 register when E <= 0 and 2^E registers otherwise; it is aligned when E <= 0 or its register number is a multiple of 2^E, and its group must end at or below register 32. A misaligned checked operand makes `legal` 0.
- R4: Single-width classes: code 0 checks vd, vs1, vs2 at grouping L; code 1 checks vd, vs2 only (vs1 ignored). Equal-width overlap between vd and a source is always permitted.
- R5: Mask-producing classes (code 2 with vs1 and vs2, code 3 with vs2 only): vd spans one register with no alignment demand; sources are aligned at L; vd may overlap a source group only when vd equals that source's first register.
- R6: Widening class code 4 (vd at L+1, vs1 and vs2 at L) is legal only when L <= 2 and `vsew` is not 3 (64-bit); a source may overlap vd only when both groups end at the same register.
- R7: Widening class code 5 checks vd and vs2 at L+1 and vs1 at L, with the limits of R6; vs2 may overlap vd freely, vs1 only at vd's high end.
- R8: Narrowing class code 6 checks vd and vs1 at L and vs2 at L+1, with the limits of R6; vd may overlap vs2 only when vd equals vs2.
- R9: For classes 0, 1, 4, 5 and 6 with `vm` = 0, a destination group that includes v0 (vd = 0) makes `legal` 0; with `vm` = 1 v0 is unrestricted.
- R10: Reduction class code 7 checks only vs2 aligned at L; widening reduction code 8 adds that `vsew` must not be 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vs_status | input | 2 | Vector-unit status field; 0 means the unit is off |
| insn_class | input | 4 | Operand-form class code (0..8) |
| vd | input | 5 | Destination register number |
| vs1 | input | 5 | First source register number |
| vs2 | input | 5 | Second source register number |
| vm | input | 1 | 1 = unmasked, 0 = masked by v0 |
| vsew | input | 2 | Element width code: 0..3 for 8..64 bits |
| vlmul | input | 3 | Signed log2 grouping code |
| legal | output | 1 | 1 when the operand set is legal |

## Verification
The assertions check on every input change the rules that reduce to a simple implication on the ports: status off, reserved grouping or class, the width limits of widening forms and widening reductions, a masked write of v0, and a misaligned source at grouping 2. The positional overlap rules (low end for narrowing and mask results, high end for widening) and the interaction of fractional groupings with alignment can only be shown by the bench's exhaustive sweep of vd, vs2 and grouping per class against its register-bitmap model.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

    localparam int REG_W    = 5;
    localparam int NUM_REGS = 1 << REG_W;
    localparam int EMUL_W   = 4;
    localparam int EXT_W    = REG_W + 2;
    localparam int NUM_OPND = 3;
    localparam int NUM_PAIR = 3;

    typedef enum logic [3:0] {
        CLS_SS_VV   = 4'd0,
        CLS_SS_VX   = 4'd1,
        CLS_MASK_VV = 4'd2,
        CLS_MASK_VX = 4'd3,
        CLS_WIDE_VV = 4'd4,
        CLS_WIDE_WV = 4'd5,
        CLS_NARR_WV = 4'd6,
        CLS_RED     = 4'd7,
        CLS_WRED    = 4'd8
    } vclass_e;

    // relation of destination element width to a source's
    typedef enum logic [1:0] {
        REL_SAME       = 2'd0,
        REL_DST_NARROW = 2'd1,
        REL_DST_WIDE   = 2'd2,
        REL_FORBID     = 2'd3
    } rel_e;

    typedef struct packed {
        logic                     used;
        logic signed [EMUL_W-1:0] emul;
    } opnd_t;

    typedef struct packed {
        logic  known;
        logic  wn_limit;
        logic  wide_red;
        logic  v0_guard;
        opnd_t dst;
        opnd_t src1;
        opnd_t src2;
        rel_e  rel1;
        rel_e  rel2;
    } role_t;

    localparam logic [2:0] LMUL_RSVD = 3'b100;
    localparam logic [2:0] LMUL_MAX8 = 3'b011;
    localparam logic [1:0] SEW_64    = 2'b11;

endpackage

// File: rtl/vlc_decode.sv
module vlc_decode
    import vlc_pkg::*;
(
    input  logic [3:0] insn_class,
    input  logic [2:0] vlmul,
    output role_t      role
);

    logic signed [EMUL_W-1:0] l_one;
    logic signed [EMUL_W-1:0] l_two;

    always_comb begin
        l_one = EMUL_W'(signed'(vlmul));
        l_two = l_one + EMUL_W'(1);
    end

    always_comb begin
        role = '0;
        role.rel1 = REL_SAME;
        role.rel2 = REL_SAME;
        unique case (vclass_e'(insn_class))
            CLS_SS_VV: begin
                role.known    = 1'b1;
                role.v0_guard = 1'b1;
                role.dst      = '{used: 1'b1, emul: l_one};
                role.src1     = '{used: 1'b1, emul: l_one};
                role.src2     = '{used: 1'b1, emul: l_one};
            end
            CLS_SS_VX: begin
                role.known    = 1'b1;
                role.v0_guard = 1'b1;
                role.dst      = '{used: 1'b1, emul: l_one};
                role.src2     = '{used: 1'b1, emul: l_one};
            end
            CLS_MASK_VV: begin
                role.known = 1'b1;
                role.dst   = '{used: 1'b1, emul: '0};
                role.src1  = '{used: 1'b1, emul: l_one};
                role.src2  = '{used: 1'b1, emul: l_one};
                role.rel1  = REL_DST_NARROW;
                role.rel2  = REL_DST_NARROW;
            end
            CLS_MASK_VX: begin
                role.known = 1'b1;
                role.dst   = '{used: 1'b1, emul: '0};
                role.src2  = '{used: 1'b1, emul: l_one};
                role.rel2  = REL_DST_NARROW;
            end
            CLS_WIDE_VV: begin
                role.known    = 1'b1;
                role.wn_limit = 1'b1;
                role.v0_guard = 1'b1;
                role.dst      = '{used: 1'b1, emul: l_two};
                role.src1     = '{used: 1'b1, emul: l_one};
                role.src2     = '{used: 1'b1, emul: l_one};
                role.rel1     = REL_DST_WIDE;
                role.rel2     = REL_DST_WIDE;
            end
            CLS_WIDE_WV: begin
                role.known    = 1'b1;
                role.wn_limit = 1'b1;
                role.v0_guard = 1'b1;
                role.dst      = '{used: 1'b1, emul: l_two};
                role.src1     = '{used: 1'b1, emul: l_one};
                role.src2     = '{used: 1'b1, emul: l_two};
                role.rel1     = REL_DST_WIDE;
                role.rel2     = REL_SAME;
            end
            CLS_NARR_WV: begin
                role.known    = 1'b1;
                role.wn_limit = 1'b1;
                role.v0_guard = 1'b1;
                role.dst      = '{used: 1'b1, emul: l_one};
                role.src1     = '{used: 1'b1, emul: l_one};
                role.src2     = '{used: 1'b1, emul: l_two};
                role.rel1     = REL_SAME;
                role.rel2     = REL_DST_NARROW;
            end
            CLS_RED: begin
                role.known = 1'b1;
                role.src2  = '{used: 1'b1, emul: l_one};
            end
            CLS_WRED: begin
                role.known    = 1'b1;
                role.wide_red = 1'b1;
                role.src2     = '{used: 1'b1, emul: l_one};
            end
            default: begin
                role.known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vlc_operand.sv
module vlc_operand
    import vlc_pkg::*;
#(
    parameter int P_REG_W  = REG_W,
    parameter int P_EMUL_W = EMUL_W,
    localparam int LP_EXT_W = P_REG_W + 2,
    localparam int LP_NREGS = 1 << P_REG_W
) (
    input  logic [P_REG_W-1:0]         reg_num,
    input  logic signed [P_EMUL_W-1:0] emul,
    input  logic                       used,
    output logic [LP_EXT_W-1:0]        g_start,
    output logic [LP_EXT_W-1:0]        g_size,
    output logic                       ok
);

    logic [LP_EXT_W-1:0] low_mask;
    logic [LP_EXT_W-1:0] g_end;
    logic                aligned;
    logic                in_range;

    always_comb begin
        g_start = LP_EXT_W'(reg_num);
        if (emul <= 0) begin
            g_size = LP_EXT_W'(1);
        end else begin
            g_size = LP_EXT_W'(1) << emul[P_EMUL_W-2:0];
        end
        low_mask = g_size - LP_EXT_W'(1);
        aligned  = (g_start & low_mask) == '0;
        g_end    = g_start + g_size;
        in_range = g_end <= LP_EXT_W'(LP_NREGS);
        ok       = !used || (aligned && in_range);
    end

endmodule

// File: rtl/vlc_overlap.sv
module vlc_overlap
    import vlc_pkg::*;
#(
    parameter int P_EXT_W = EXT_W
) (
    input  logic [P_EXT_W-1:0] d_start,
    input  logic [P_EXT_W-1:0] d_size,
    input  logic [P_EXT_W-1:0] s_start,
    input  logic [P_EXT_W-1:0] s_size,
    input  rel_e               rel,
    input  logic               used,
    output logic               ok
);

    logic [P_EXT_W-1:0] d_end;
    logic [P_EXT_W-1:0] s_end;
    logic [P_EXT_W-1:0] span_hi;
    logic [P_EXT_W-1:0] span_lo;
    logic               hit;
    logic               placed;

    always_comb begin
        d_end   = d_start + d_size;
        s_end   = s_start + s_size;
        span_hi = (d_end > s_end) ? d_end : s_end;
        span_lo = (d_start < s_start) ? d_start : s_start;
        hit     = (span_hi - span_lo) < (d_size + s_size);
        unique case (rel)
            REL_SAME:       placed = 1'b1;
            REL_DST_NARROW: placed = (d_start == s_start);
            REL_DST_WIDE:   placed = (d_end == s_end);
            REL_FORBID:     placed = 1'b0;
            default:        placed = 1'b0;
        endcase
        ok = !used || !hit || placed;
    end

endmodule

// File: rtl/vlc_legal_check.sv
module vlc_legal_check
    import vlc_pkg::*;
#(
    parameter int P_REG_W  = REG_W,
    parameter int P_EMUL_W = EMUL_W,
    localparam int LP_EXT_W = P_REG_W + 2
) (
    input  logic [1:0]         vs_status,
    input  logic [3:0]         insn_class,
    input  logic [P_REG_W-1:0] vd,
    input  logic [P_REG_W-1:0] vs1,
    input  logic [P_REG_W-1:0] vs2,
    input  logic               vm,
    input  logic [1:0]         vsew,
    input  logic [2:0]         vlmul,
    output logic               legal
);

    role_t role;

    vlc_decode u_decode (
        .insn_class (insn_class),
        .vlmul      (vlmul),
        .role       (role)
    );

    // operand slots: 0 = destination, 1 = vs1, 2 = vs2
    logic [P_REG_W-1:0]         op_reg  [NUM_OPND];
    opnd_t                      op_role [NUM_OPND];
    logic [LP_EXT_W-1:0]        op_start[NUM_OPND];
    logic [LP_EXT_W-1:0]        op_size [NUM_OPND];
    logic [NUM_OPND-1:0]        op_ok;

    always_comb begin
        op_reg[0]  = vd;
        op_reg[1]  = vs1;
        op_reg[2]  = vs2;
        op_role[0] = role.dst;
        op_role[1] = role.src1;
        op_role[2] = role.src2;
    end

    for (genvar gi = 0; gi < NUM_OPND; gi++) begin : g_opnd
        vlc_operand #(
            .P_REG_W  (P_REG_W),
            .P_EMUL_W (P_EMUL_W)
        ) u_opnd (
            .reg_num (op_reg[gi]),
            .emul    (op_role[gi].emul),
            .used    (op_role[gi].used),
            .g_start (op_start[gi]),
            .g_size  (op_size[gi]),
            .ok      (op_ok[gi])
        );
    end

    // pair slots: 0 = vs1, 1 = vs2, 2 = mask register v0
    logic [LP_EXT_W-1:0] pr_start[NUM_PAIR];
    logic [LP_EXT_W-1:0] pr_size [NUM_PAIR];
    rel_e                pr_rel  [NUM_PAIR];
    logic [NUM_PAIR-1:0] pr_used;
    logic [NUM_PAIR-1:0] pr_ok;

    always_comb begin
        pr_start[0] = op_start[1];
        pr_size[0]  = op_size[1];
        pr_rel[0]   = role.rel1;
        pr_used[0]  = role.src1.used && role.dst.used;
        pr_start[1] = op_start[2];
        pr_size[1]  = op_size[2];
        pr_rel[1]   = role.rel2;
        pr_used[1]  = role.src2.used && role.dst.used;
        pr_start[2] = '0;
        pr_size[2]  = LP_EXT_W'(1);
        pr_rel[2]   = REL_FORBID;
        pr_used[2]  = role.v0_guard && !vm;
    end

    for (genvar gp = 0; gp < NUM_PAIR; gp++) begin : g_pair
        vlc_overlap #(
            .P_EXT_W (LP_EXT_W)
        ) u_ovl (
            .d_start (op_start[0]),
            .d_size  (op_size[0]),
            .s_start (pr_start[gp]),
            .s_size  (pr_size[gp]),
            .rel     (pr_rel[gp]),
            .used    (pr_used[gp]),
            .ok      (pr_ok[gp])
        );
    end

    logic unit_on;
    logic lmul_ok;
    logic width_ok;
    logic red_ok;

    always_comb begin
        unit_on  = vs_status != 2'b00;
        lmul_ok  = vlmul != LMUL_RSVD;
        width_ok = !role.wn_limit || ((vlmul != LMUL_MAX8) && (vsew != SEW_64));
        red_ok   = !role.wide_red || (vsew != SEW_64);
        legal    = unit_on && lmul_ok && role.known && width_ok && red_ok
                   && (&op_ok) && (&pr_ok);
    end

endmodule

// File: rtl/vlc_legal_check_sva.sv
module vlc_legal_check_sva (
    input logic [1:0] vs_status,
    input logic [3:0] insn_class,
    input logic [4:0] vd,
    input logic [4:0] vs1,
    input logic [4:0] vs2,
    input logic       vm,
    input logic [1:0] vsew,
    input logic [2:0] vlmul,
    input logic       legal
);

    logic is_wn;
    logic is_guarded;
    logic is_single;

    always_comb begin
        is_wn      = (insn_class == 4'd4) || (insn_class == 4'd5) || (insn_class == 4'd6);
        is_guarded = (insn_class <= 4'd1) || is_wn;
        is_single  = (insn_class <= 4'd3) || (insn_class == 4'd7) || (insn_class == 4'd8);

        AST_UNIT_OFF: assert ((vs_status != 2'b00) || !legal)
            else $error("unit off but legal");  // R1
        AST_RSVD_LMUL: assert ((vlmul != 3'b100) || !legal)
            else $error("reserved grouping accepted");  // R2
        AST_BAD_CLASS: assert ((insn_class <= 4'd8) || !legal)
            else $error("undefined class accepted");  // R2
        AST_WIDE_LIMIT: assert (!(is_wn && ((vsew == 2'b11) || (vlmul == 3'b011))) || !legal)
            else $error("width limit broken");  // R6
        AST_WRED_SEW: assert (!((insn_class == 4'd8) && (vsew == 2'b11)) || !legal)
            else $error("wide reduction at 64 bits");  // R10
        AST_MASK_V0: assert (!(is_guarded && !vm && (vd == 5'd0)) || !legal)
            else $error("masked write of v0");  // R9
        AST_ALIGN_SRC: assert (!(is_single && (vlmul == 3'b010) && (vs2[1:0] != 2'b00)) || !legal)
            else $error("misaligned vs2 accepted");  // R3
    end

endmodule

bind vlc_legal_check vlc_legal_check_sva u_sva (.*);

// File: tb/vlc_legal_check_bench.sv
module vlc_legal_check_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic [1:0] vs_status;
    logic [3:0] insn_class;
    logic [4:0] vd;
    logic [4:0] vs1;
    logic [4:0] vs2;
    logic       vm;
    logic [1:0] vsew;
    logic [2:0] vlmul;
    logic       legal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlc_legal_check u_vlc_legal_check (
        .vs_status  (vs_status),
        .insn_class (insn_class),
        .vd         (vd),
        .vs1        (vs1),
        .vs2        (vs2),
        .vm         (vm),
        .vsew       (vsew),
        .vlmul      (vlmul),
        .legal      (legal)
    );

    // ---------------- reference model on register bitmaps ----------------
    function automatic int gsz(int e);
        return (e <= 0) ? 1 : (1 << e);
    endfunction

    function automatic logic [63:0] gmask(int r, int e);
        return ((64'd1 << gsz(e)) - 64'd1) << r;
    endfunction

    function automatic bit fits(int r, int e);
        return ((r % gsz(e)) == 0) && (gmask(r, e)[63:32] == 32'd0);
    endfunction

    // rel: 0 same width, 1 destination narrower, 2 destination wider
    function automatic bit pair_fine(int d, int de, int s, int se, int rel);
        if ((gmask(d, de) & gmask(s, se)) == 64'd0) return 1'b1;
        if (rel == 0) return 1'b1;
        if (rel == 1) return d == s;
        return (d + gsz(de)) == (s + gsz(se));
    endfunction

    function automatic bit ref_legal(int cls, int d, int a, int b, bit m,
                                     int sew, int lm, int st);
        int l;
        bit r;
        if (st == 0) return 1'b0;                  // R1
        if (lm == 4) return 1'b0;                  // R2
        l = (lm > 3) ? lm - 8 : lm;
        case (cls)
            0: r = fits(d, l) && fits(a, l) && fits(b, l) && (m || d != 0);
            1: r = fits(d, l) && fits(b, l) && (m || d != 0);
            2: r = fits(a, l) && fits(b, l) && pair_fine(d, 0, a, l, 1)
                   && pair_fine(d, 0, b, l, 1);
            3: r = fits(b, l) && pair_fine(d, 0, b, l, 1);
            4: r = (l <= 2) && (sew != 3) && fits(d, l + 1) && fits(a, l) && fits(b, l)
                   && pair_fine(d, l + 1, a, l, 2) && pair_fine(d, l + 1, b, l, 2)
                   && (m || d != 0);
            5: r = (l <= 2) && (sew != 3) && fits(d, l + 1) && fits(a, l) && fits(b, l + 1)
                   && pair_fine(d, l + 1, a, l, 2) && (m || d != 0);
            6: r = (l <= 2) && (sew != 3) && fits(d, l) && fits(a, l) && fits(b, l + 1)
                   && pair_fine(d, l, b, l + 1, 1) && (m || d != 0);
            7: r = fits(b, l);
            8: r = fits(b, l) && (sew != 3);
            default: r = 1'b0;                     // R2
        endcase
        return r;
    endfunction

    function automatic string tag_of(int cls, int lm, int st);
        if (st == 0) return "R1";
        if (lm == 4 || cls > 8) return "R2";
        case (cls)
            0, 1: return "R4";
            2, 3: return "R5";
            4:    return "R6";
            5:    return "R7";
            6:    return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic apply_and_check(int cls, int d, int a, int b, bit m,
                                   int sew, int lm, int st, string tag);
        bit exp;
        @(posedge clk);
        #1;
        insn_class = 4'(cls);
        vd         = 5'(d);
        vs1        = 5'(a);
        vs2        = 5'(b);
        vm         = m;
        vsew       = 2'(sew);
        vlmul      = 3'(lm);
        vs_status  = 2'(st);
        #(CLK_PERIOD/2);
        exp = ref_legal(cls, d, a, b, m, sew, lm, st);
        n_checks++;
        if (legal !== exp) begin
            n_fails++;
            $display("FAIL %s cls=%0d vd=%0d vs1=%0d vs2=%0d vm=%0d sew=%0d lmul=%0d st=%0d: actual %0b expected %0b",
                     tag, cls, d, a, b, m, sew, lm, st, legal, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        vs_status = '0; insn_class = '0; vd = '0; vs1 = '0; vs2 = '0;
        vm = 1'b0; vsew = '0; vlmul = '0;
        #(CLK_PERIOD/2 + 1);
        // idle state: unit off, legal must be low (R1)
        n_checks++;
        if (legal !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 idle: actual %0b expected 0", legal);
        end

        // directed corners
        apply_and_check(1, 2, 0, 1, 1, 0, 1, 1, "R3");   // vs2 odd at grouping 2
        apply_and_check(1, 2, 0, 2, 1, 0, 1, 1, "R3");
        apply_and_check(0, 4, 9, 8, 1, 1, 2, 3, "R3");   // vs1 misaligned
        apply_and_check(1, 0, 0, 4, 0, 0, 0, 1, "R9");   // masked write of v0
        apply_and_check(1, 0, 0, 4, 1, 0, 0, 1, "R9");
        apply_and_check(3, 0, 0, 4, 0, 0, 0, 1, "R5");   // mask result may be v0
        apply_and_check(2, 4, 6, 4, 1, 0, 1, 2, "R5");   // vd at vs2 start
        apply_and_check(2, 5, 6, 4, 1, 0, 1, 2, "R5");   // vd inside vs2 group
        apply_and_check(4, 4, 8, 6, 1, 0, 1, 1, "R6");   // high-end overlap
        apply_and_check(4, 4, 8, 4, 1, 0, 1, 1, "R6");   // low-end overlap
        apply_and_check(4, 8, 2, 4, 1, 3, 0, 1, "R6");   // 64-bit element
        apply_and_check(4, 0, 8, 16, 1, 0, 3, 1, "R6");  // grouping 8
        apply_and_check(5, 4, 6, 4, 1, 0, 1, 1, "R7");
        apply_and_check(6, 4, 8, 4, 1, 0, 0, 1, "R8");
        apply_and_check(6, 5, 8, 4, 1, 0, 0, 1, "R8");
        apply_and_check(8, 3, 3, 4, 1, 3, 1, 1, "R10");
        apply_and_check(7, 3, 3, 4, 1, 3, 1, 1, "R10");
        apply_and_check(0, 0, 0, 0, 1, 0, 4, 1, "R2");
        apply_and_check(12, 0, 0, 0, 1, 0, 0, 1, "R2");
        apply_and_check(0, 2, 2, 2, 1, 0, 0, 0, "R1");

        // exhaustive vd x vs2 x grouping per class, random other fields
        for (int cls = 0; cls < 9; cls++) begin
            for (int lm = 0; lm < 8; lm++) begin
                for (int d = 0; d < 32; d++) begin
                    for (int b = 0; b < 32; b++) begin
                        int a;
                        int st;
                        a  = (($urandom % 4) == 0) ? d : int'($urandom % 32);
                        st = (($urandom % 16) == 0) ? 0 : int'(1 + ($urandom % 3));
                        apply_and_check(cls, d, a, b, 1'($urandom), int'($urandom % 4),
                                        lm, st, tag_of(cls, lm, st));
                    end
                end
            end
        end

        // undefined classes and unit-off, random operands
        for (int k = 0; k < 1000; k++) begin
            int cls;
            int st;
            cls = int'($urandom % 16);
            st  = int'($urandom % 4);
            apply_and_check(cls, int'($urandom % 32), int'($urandom % 32), int'($urandom % 32),
                            1'($urandom), int'($urandom % 4), int'($urandom % 8), st,
                            tag_of(cls, 0, st));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule